// File: doc/BRIEF.md
# Stuck DMA Hang Signature Detector

This block decides whether the transmit DMA engine has frozen in one of two known deadlock states. It watches four 32-bit debug status words, here called word3, word4, word5 and word6, which arrive as plain inputs. A start request captures all four words as a snapshot. The block then compares the live words with that snapshot on each of a fixed number of later sample ticks. A sample tick is a cycle in which the clock enable is high. If any word moves during that window, the engine is still making progress and the block reports "no hang".

If the snapshot holds for the whole window, the block classifies it. The first hang signature needs two things: a 5-bit DMA chain-state value of 6 somewhere among the packed fields of word4 or word5, and a completion state of 1 in word6. The second signature needs three queue-state fields of word3 to hold fixed values together. A frozen snapshot that fits neither signature is reported as an unknown hang.

A companion baseband check runs alongside this block. When it already reports a hang, this check is skipped, because a hung baseband implies a hung DMA. The answer always comes as a 2-bit code qualified by a one-cycle done pulse.

Top module: `dma_hang_detect`

## Requirements
- R1: A start request seen while idle with `bb_hung` low snapshots all four words in that cycle. The block then compares the live words with the snapshot on each of the next `STABLE_SAMPLES` (default 50) cycles in which `sample_en` is high. Cycles with `sample_en` low neither count toward the window nor compare.
- R2: If any bit of any word differs from the snapshot on a sample tick, the check ends. `done` pulses in the following cycle with `result` = 2'b00 (no hang).
- R3: If the words stay equal to the snapshot through the final tick of the window, `done` pulses in the cycle after that tick with the classification of the snapshot.
- R4: Signature 1 (code 2'b01) needs word6[1:0] = 2'b01. It also needs the value 5'h06 in at least one 5-bit field: either word4[5i+4:5i] for i = 0..5, or word5[5i+4:5i] for i = 0..3.
- R5: Signature 2 (code 2'b10) needs all three of word3[21:18] = 4'h9, word3[25:22] = 4'h8 and word3[28:26] = 3'h4.
- R6: When a snapshot fits both signatures, the code is 2'b01.
- R7: A stable snapshot that fits neither signature yields code 2'b11 (unknown hang).
- R8: A start request seen while idle with `bb_hung` high runs no window. `done` pulses in the next cycle with `result` = 2'b00.
- R9: A start request that arrives while a window is running is ignored. It neither retakes the snapshot nor lengthens or ends the window.
- R10: `done` lasts exactly one cycle per accepted start. `result` keeps its last value in every cycle in which `done` is low.
- R11: After reset, `done` is 0 and `result` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a hang check |
| sample_en | input | 1 | Sample tick enable |
| bb_hung | input | 1 | Companion baseband check reports a hang |
| dbg_word3 | input | 32 | Queue state debug word |
| dbg_word4 | input | 32 | DMA chain state word, six packed fields |
| dbg_word5 | input | 32 | DMA chain state word, four packed fields |
| dbg_word6 | input | 32 | DMA completion state word |
| done | output | 1 | One-cycle result qualifier |
| result | output | 2 | 00 none, 01 signature 1, 10 signature 2, 11 unknown |

## Verification
The hardest case to reach from the ports is a disturbance that lands exactly on the last tick of a gapped window. It must still report no hang, while a start request arriving mid-window must change nothing. The bench builds each snapshot field by field, so the chain value 6 sits in each of the ten packed positions in turn, crossed with all four completion values. It then flips single bits of each word on the first, middle and final tick. Tick gaps and mid-window start pulses are mixed in, and a pseudo-random pass over all four words is checked against an arithmetic model of the two signatures.

// File: rtl/dhd_pkg.sv
package dhd_pkg;

    localparam int WORD_W        = 32;
    localparam int CHAIN_FIELD_W = 5;
    localparam int CHAIN_FIELDS4 = 6;
    localparam int CHAIN_FIELDS5 = 4;

    localparam logic [CHAIN_FIELD_W-1:0] CHAIN_STUCK_VAL = 5'h06;
    localparam logic [1:0]               CMPL_STUCK_VAL  = 2'b01;
    localparam logic [3:0]               STITCH_VAL      = 4'h9;
    localparam logic [3:0]               FETCH_VAL       = 4'h8;
    localparam logic [2:0]               QDONE_VAL       = 3'h4;

    typedef enum logic [1:0] {
        HANG_NONE    = 2'b00,
        HANG_SIG1    = 2'b01,
        HANG_SIG2    = 2'b10,
        HANG_UNKNOWN = 2'b11
    } hang_code_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_WATCH = 1'b1
    } dhd_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] w3;
        logic [WORD_W-1:0] w4;
        logic [WORD_W-1:0] w5;
        logic [WORD_W-1:0] w6;
    } dbg_words_t;

endpackage

// File: rtl/dhd_field_scan.sv
module dhd_field_scan #(
    parameter int WORD_W     = 32,
    parameter int FIELD_W    = 5,
    parameter int NUM_FIELDS = 6
) (
    input  logic [WORD_W-1:0]  word,
    input  logic [FIELD_W-1:0] target,
    output logic               hit
);
    logic [NUM_FIELDS-1:0] field_hit;

    generate
        for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
            assign field_hit[i] = (word[i*FIELD_W +: FIELD_W] == target);
        end
    endgenerate

    assign hit = |field_hit;
endmodule

// File: rtl/dhd_classify.sv
module dhd_classify
    import dhd_pkg::*;
(
    input  dbg_words_t snap,
    output hang_code_e code
);
    logic chain_hit4;
    logic chain_hit5;
    logic sig1_match;
    logic sig2_match;

    dhd_field_scan #(
        .WORD_W    (WORD_W),
        .FIELD_W   (CHAIN_FIELD_W),
        .NUM_FIELDS(CHAIN_FIELDS4)
    ) u_scan4 (
        .word  (snap.w4),
        .target(CHAIN_STUCK_VAL),
        .hit   (chain_hit4)
    );

    dhd_field_scan #(
        .WORD_W    (WORD_W),
        .FIELD_W   (CHAIN_FIELD_W),
        .NUM_FIELDS(CHAIN_FIELDS5)
    ) u_scan5 (
        .word  (snap.w5),
        .target(CHAIN_STUCK_VAL),
        .hit   (chain_hit5)
    );

    always_comb begin
        sig1_match = (chain_hit4 || chain_hit5) && (snap.w6[1:0] == CMPL_STUCK_VAL);
        sig2_match = (snap.w3[21:18] == STITCH_VAL) &&
                     (snap.w3[25:22] == FETCH_VAL)  &&
                     (snap.w3[28:26] == QDONE_VAL);
        if (sig1_match)      code = HANG_SIG1;
        else if (sig2_match) code = HANG_SIG2;
        else                 code = HANG_UNKNOWN;
    end
endmodule

// File: rtl/dma_hang_detect.sv
module dma_hang_detect
    import dhd_pkg::*;
#(
    parameter int STABLE_SAMPLES = 50
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        sample_en,
    input  logic        bb_hung,
    input  logic [31:0] dbg_word3,
    input  logic [31:0] dbg_word4,
    input  logic [31:0] dbg_word5,
    input  logic [31:0] dbg_word6,
    output logic        done,
    output logic [1:0]  result
);
    localparam int CNT_W = $clog2(STABLE_SAMPLES + 1);
    localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(STABLE_SAMPLES - 1);

    typedef struct packed {
        dhd_state_e       state;
        logic [CNT_W-1:0] cnt;
        dbg_words_t       snap;
        logic             done;
        hang_code_e       result;
    } dhd_regs_t;

    dhd_regs_t  regs_d;
    dhd_regs_t  regs_q;
    dbg_words_t live;
    hang_code_e class_code;

    assign live = '{w3: dbg_word3, w4: dbg_word4, w5: dbg_word5, w6: dbg_word6};

    dhd_classify u_classify (
        .snap(regs_q.snap),
        .code(class_code)
    );

    always_comb begin
        regs_d      = regs_q;
        regs_d.done = 1'b0;
        unique case (regs_q.state)
            ST_IDLE: begin
                if (start) begin
                    if (bb_hung) begin
                        regs_d.done   = 1'b1;
                        regs_d.result = HANG_NONE;
                    end else begin
                        regs_d.snap  = live;
                        regs_d.cnt   = '0;
                        regs_d.state = ST_WATCH;
                    end
                end
            end
            ST_WATCH: begin
                if (sample_en) begin
                    if (live != regs_q.snap) begin
                        regs_d.done   = 1'b1;
                        regs_d.result = HANG_NONE;
                        regs_d.state  = ST_IDLE;
                    end else if (regs_q.cnt == LAST_TICK) begin
                        regs_d.done   = 1'b1;
                        regs_d.result = class_code;
                        regs_d.state  = ST_IDLE;
                    end else begin
                        regs_d.cnt = regs_q.cnt + 1'b1;
                    end
                end
            end
            default: regs_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.state  <= ST_IDLE;
            regs_q.cnt    <= '0;
            regs_q.snap   <= '0;
            regs_q.done   <= 1'b0;
            regs_q.result <= HANG_NONE;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign done   = regs_q.done;
    assign result = regs_q.result;
endmodule

// File: rtl/dhd_checker.sv
module dhd_checker #(
    parameter int STABLE_SAMPLES = 50
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         sample_en,
    input logic         bb_hung,
    input logic [127:0] live_words,
    input logic [127:0] snap_words,
    input logic         busy,
    input logic         done,
    input logic [1:0]   result
);
    logic [15:0] tick_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_cnt <= '0;
        end else if (!busy && start && !bb_hung) begin
            tick_cnt <= '0;
        end else if (busy && sample_en) begin
            tick_cnt <= tick_cnt + 16'd1;
        end
    end

    // R2: a moved word on a tick ends the check with no hang
    a_r2_mismatch_none: assert property (@(posedge clk) disable iff (!rst_n)
        busy && sample_en && (live_words != snap_words) |=> done && (result == 2'b00));

    // R3: a hang code only after the full window of ticks
    a_r3_full_window: assert property (@(posedge clk) disable iff (!rst_n)
        done && (result != 2'b00) |-> tick_cnt == 16'(STABLE_SAMPLES));

    // R8: baseband hang skips the window
    a_r8_bb_skip: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && start && bb_hung |=> done && (result == 2'b00) && !busy);

    // R9: start during a window leaves the snapshot untouched
    a_r9_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start && !sample_en |=> busy && $stable(snap_words));

    // R10: result holds while done is low
    a_r10_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));

    // R10: done ends the window
    a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

bind dma_hang_detect dhd_checker #(.STABLE_SAMPLES(STABLE_SAMPLES)) u_dhd_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .sample_en (sample_en),
    .bb_hung   (bb_hung),
    .live_words({dbg_word3, dbg_word4, dbg_word5, dbg_word6}),
    .snap_words(regs_q.snap),
    .busy      (regs_q.state == dhd_pkg::ST_WATCH),
    .done      (done),
    .result    (result)
);

// File: tb/dma_hang_detect_test.sv
`timescale 1ns/1ps
module dma_hang_detect_test;
    localparam int STABLE = 50;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        sample_en = 1'b0;
    logic        bb_hung = 1'b0;
    logic [31:0] w3 = '0, w4 = '0, w5 = '0, w6 = '0;
    logic        done;
    logic [1:0]  result;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    dma_hang_detect #(.STABLE_SAMPLES(STABLE)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .sample_en(sample_en),
        .bb_hung(bb_hung), .dbg_word3(w3), .dbg_word4(w4), .dbg_word5(w5),
        .dbg_word6(w6), .done(done), .result(result)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] model(input logic [31:0] a3, a4, a5, a6);
        bit chain = 0;
        bit s1, s2;
        for (int i = 0; i < 6; i++) if (((a4 >> (5*i)) & 32'h1f) == 32'd6) chain = 1;
        for (int i = 0; i < 4; i++) if (((a5 >> (5*i)) & 32'h1f) == 32'd6) chain = 1;
        s1 = chain && ((a6 & 32'h3) == 32'd1);
        s2 = (((a3 >> 18) & 32'hf) == 32'd9) && (((a3 >> 22) & 32'hf) == 32'd8) &&
             (((a3 >> 26) & 32'h7) == 32'd4);
        if (s1) return 2'b01;
        if (s2) return 2'b10;
        return 2'b11;
    endfunction

    // bad_tick > 0 flips a bit of word bad_word (0..3 = word3..word6) on that tick
    task automatic run_one(input logic [31:0] a3, a4, a5, a6, input bit bb,
                           input int bad_tick, input int bad_word, input int gap,
                           input int busy_start_tick, input string tag);
        int ticks = 0;
        int end_tick;
        logic [1:0] exp;
        bit seen = 0;
        @(negedge clk);
        w3 = a3; w4 = a4; w5 = a5; w6 = a6;
        bb_hung = bb; start = 1'b1; sample_en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        if (bb) begin
            check({tag, " R8 done"}, {31'd0, done}, 32'd1);
            check({tag, " R8 result"}, {30'd0, result}, 32'd0);
            bb_hung = 1'b0;
            @(negedge clk);
            check({tag, " R10 single"}, {31'd0, done}, 32'd0);
            return;
        end
        end_tick = (bad_tick > 0) ? bad_tick : STABLE;
        exp = (bad_tick > 0) ? 2'b00 : model(a3, a4, a5, a6);
        for (int cyc = 0; cyc < 400 && !seen; cyc++) begin
            bit en;
            en = (gap == 0) || ((cyc % (gap + 1)) == gap);
            sample_en = en;
            if (en && (ticks + 1 == bad_tick)) begin
                case (bad_word)
                    0: w3 = w3 ^ (32'd1 << (bad_tick % 32));
                    1: w4 = w4 ^ (32'd1 << (bad_tick % 32));
                    2: w5 = w5 ^ (32'd1 << (bad_tick % 32));
                    default: w6 = w6 ^ (32'd1 << (bad_tick % 32));
                endcase
            end
            start = (busy_start_tick >= 0) && (ticks == busy_start_tick);
            @(posedge clk);
            if (en) ticks++;
            @(negedge clk);
            start = 1'b0;
            sample_en = 1'b0;
            if (done) begin
                seen = 1;
                check({tag, " R1/R3 end tick"}, ticks, end_tick);
                check({tag, " result"}, {30'd0, result}, {30'd0, exp});
            end else if (ticks >= end_tick && en) begin
                check({tag, " R3 done missing"}, 32'd0, 32'd1);
                seen = 1;
            end
        end
        w3 = a3; w4 = a4; w5 = a5; w6 = a6;
        @(negedge clk);
        check({tag, " R10 single pulse"}, {31'd0, done}, 32'd0);
        check({tag, " R10 held"}, {30'd0, result}, {30'd0, exp});
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles >= 150000 && !finished) begin
            n_fail++;
            $display("FAIL watchdog actual %0d expected %0d", cycles, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr = 32'hACE1_2468;
        logic [31:0] base4 = 32'h3FFF_FFFF;
        logic [31:0] base5 = 32'hFFFF_FFFF;
        logic [31:0] sig2w = (32'd4 << 26) | (32'd8 << 22) | (32'd9 << 18);
        repeat (3) @(negedge clk);
        check("R11 done", {31'd0, done}, 32'd0);
        check("R11 result", {30'd0, result}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 / R7: chain value in each field, every completion value
        for (int f = 0; f < 10; f++) begin
            for (int lo = 0; lo < 4; lo++) begin
                logic [31:0] a4 = base4, a5 = base5;
                if (f < 6) a4 = (a4 & ~(32'h1f << (5*f))) | (32'd6 << (5*f));
                else       a5 = (a5 & ~(32'h1f << (5*(f-6)))) | (32'd6 << (5*(f-6)));
                run_one(32'h0, a4, a5, 32'hFFFF_FFFC | 32'(lo), 0, 0, 0, 0, -1, "R4 sweep");
            end
            // near miss value 7 in the same field
            begin
                logic [31:0] a4 = base4, a5 = base5;
                if (f < 6) a4 = (a4 & ~(32'h1f << (5*f))) | (32'd7 << (5*f));
                else       a5 = (a5 & ~(32'h1f << (5*(f-6)))) | (32'd7 << (5*(f-6)));
                run_one(32'h0, a4, a5, 32'h1, 0, 0, 0, 0, -1, "R7 near miss");
            end
        end

        // R5: exact signature 2 and each field disturbed
        run_one(sig2w, base4, base5, 32'h1, 0, 0, 0, 0, -1, "R5 exact");
        run_one(sig2w | 32'hE003_FFFF, base4, base5, 32'h0, 0, 0, 0, 1, -1, "R5 exact other bits");
        run_one(sig2w ^ (32'd1 << 18), base4, base5, 32'h1, 0, 0, 0, 0, -1, "R5 R7 stitch off");
        run_one(sig2w ^ (32'd1 << 25), base4, base5, 32'h1, 0, 0, 0, 0, -1, "R5 R7 fetch off");
        run_one(sig2w ^ (32'd1 << 28), base4, base5, 32'h1, 0, 0, 0, 0, -1, "R5 R7 qdone off");

        // R6: both signatures
        run_one(sig2w, base4 & ~32'h1f | 32'd6, base5, 32'h1, 0, 0, 0, 0, -1, "R6 both");
        run_one(sig2w, base4, (base5 & ~(32'h1f << 15)) | (32'd6 << 15), 32'h5, 0, 0, 0, 2, -1, "R6 both w5");

        // R2: mismatch on first, middle and last tick of each word
        for (int w = 0; w < 4; w++) begin
            run_one(sig2w, base4, base5, 32'h1, 0, 1, w, 0, -1, "R2 first tick");
            run_one(sig2w, base4, base5, 32'h1, 0, 25, w, 1, -1, "R2 mid tick");
            run_one(sig2w, base4, base5, 32'h1, 0, STABLE, w, 2, -1, "R2 last tick");
        end

        // R8: baseband hang skips
        run_one(sig2w, base4, base5, 32'h1, 1, 0, 0, 0, -1, "R8 skip");
        run_one(32'h0, 32'd6, base5, 32'h1, 1, 0, 0, 0, -1, "R8 skip sig1");

        // R9: start while busy is ignored
        run_one(sig2w, base4, base5, 32'h0, 0, 0, 0, 0, 10, "R9 busy start");
        run_one(32'h0, 32'd6, base5, 32'h1, 0, 0, 0, 1, 30, "R9 busy start gap");

        // R1 / R7: pseudo-random words with tick gaps
        for (int k = 0; k < 24; k++) begin
            logic [31:0] r[4];
            for (int j = 0; j < 4; j++) begin
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                r[j] = lfsr * 32'h9E37_79B9;
            end
            if (k % 3 == 0) r[1] = (r[1] & ~32'h3E0) | (32'd6 << 5);
            if (k % 4 == 1) r[0] = (r[0] & ~32'h1FFC_0000) | sig2w;
            run_one(r[0], r[1], r[2], r[3], 0, 0, 0, k % 3, -1, "R1 R7 random");
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule